// File: doc/BRIEF.md
# Dual Match Timer

This peripheral holds two independent 16-bit counters behind a small 32-bit register port. Each counter has a loadable value, a prescale divider and a 5-bit control word. The control word sets run or stop, the count direction, and one of eight end conditions. A counter can stop when it reaches zero, stop when it equals one of six match registers that both counters share, or run freely and wrap.

A second register window holds six sticky status flags, one for each match register, and a six-bit enable mask. The single level interrupt is raised while any enabled flag is set. Software acknowledges a flag by writing a one to its bit position.

The usual one-shot use runs as follows. Software clears match register 0, loads a delta into a counter and starts it counting down with end condition 1. The counter then raises status bit 0 when it reaches zero and stays there until software touches it again.

Top module: `dual_match_timer`

## Requirements
- R1: After reset, both control words read 0x10 (stopped, down, end condition 0). Every counter, divider, match register, the status and the mask read 0. The interrupt output is low.
- R2: The register map is as follows, with bus_win=0 selecting the timer window.
  - Timer 1: value at 0x00, divider at 0x04, control at 0x08.
  - Timer 2: value at 0x0C, divider at 0x10, control at 0x14.
  - Match register x (x = 0..5): at 0x18+4x.
  - Each register reads back what was written, masked to 16 bits, or to 5 bits for control.
  - With bus_win=1, status is at 0x00 and the mask is at 0x04 (6 bits each).
- R3: While control bit 4 is 1, the counter keeps its value.
- R4: With control bit 4 at 0, the counter steps by +1 when control bit 3 is 1 and by -1 when it is 0.
- R5: A divider value N makes a running counter step once every N+1 clocks. The first step comes N+1 clocks after the control write. N=0 steps every clock.
- R6: End condition 7 (control bits 2:0) runs forever. Counting up wraps 0xFFFF to 0x0000, and counting down wraps 0x0000 to 0xFFFF.
- R7: End condition 0 stops the counter at zero and holds it there. It sets no status bit.
- R8: End condition x+1 (x = 0..5) stops the counter when it equals match register x, sets status bit x and holds the value. Both counters can do this independently.
- R9: A counter held at its end condition resumes after software writes its value register or its control register.
- R10: Writing to status (window 1, offset 0x00) clears each bit written as 1 and leaves the bits written as 0 unchanged. A status bit stays set until it is cleared this way.
- R11: The interrupt output is high exactly while some status bit is set and its mask bit is 1.
- R12: If a status bit is set by a match in the same cycle that software clears it, the bit ends up set.
- R13: Reads from unmapped offsets in either window return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_win | input | 1 | Window select: 0 timer registers, 1 interrupt registers |
| bus_addr | input | 8 | Byte offset within the window |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr in the same cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
The in-RTL properties check several rules on every cycle:
- a stopped counter or one held at its end condition never moves;
- a counter never moves by more than one step per clock;
- the prescaler never passes its divider value;
- a status bit never drops without an acknowledge;
- a match arriving together with an acknowledge always leaves its bit set.

Only the bench scenarios show the rest: the exact step timing for a given divider, the wrap values in both directions, and which status bit a given end condition selects. They also show that writing the value or control register releases a held counter, and how the mask gates the interrupt.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    localparam int DEF_CNT_W     = 16;
    localparam int DEF_NUM_MATCH = 6;
    localparam int ADDR_W        = 8;
    localparam int DATA_W        = 32;
    localparam int NUM_TIMERS    = 2;

    // register layout (byte offsets)
    localparam int GRP_STRIDE = 12;
    localparam int OFF_VAL    = 0;
    localparam int OFF_DIV    = 4;
    localparam int OFF_CTRL   = 8;
    localparam int OFF_MATCH  = 24;
    localparam int OFF_STS    = 0;
    localparam int OFF_MSK    = 4;

    typedef struct packed {
        logic       stop;    // bit 4
        logic       up;      // bit 3
        logic [2:0] endsel;  // bits 2:0
    } tctrl_t;

    localparam tctrl_t CTRL_RESET = '{stop: 1'b1, up: 1'b0, endsel: 3'd0};

    typedef enum logic [1:0] {
        END_FREE,
        END_ZERO,
        END_MATCH
    } end_kind_e;

    function automatic end_kind_e end_kind(input logic [2:0] sel, input int nmatch);
        if (sel == 3'd0)
            return END_ZERO;
        if (sel != 3'd7 && int'(sel) <= nmatch)
            return END_MATCH;
        return END_FREE;
    endfunction

    function automatic logic addr_is(input logic [ADDR_W-1:0] a, input int off);
        return a == ADDR_W'(off);
    endfunction

endpackage

// File: rtl/dmt_counter.sv
module dmt_counter
    import dmt_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int NUM_MATCH = 6,
    parameter int DIV_W     = 16
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                val_we,
    input  logic                                div_we,
    input  logic                                ctrl_we,
    input  logic [CNT_W-1:0]                    val_wdata,
    input  logic [DIV_W-1:0]                    div_wdata,
    input  tctrl_t                              ctrl_wdata,
    input  logic [NUM_MATCH-1:0][CNT_W-1:0]     match_i,
    output logic [CNT_W-1:0]                    cnt_o,
    output logic [DIV_W-1:0]                    div_o,
    output tctrl_t                              ctrl_o,
    output logic [NUM_MATCH-1:0]                hit_o
);

    localparam int IDX_W = (NUM_MATCH > 1) ? $clog2(NUM_MATCH) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] pre_q;
    tctrl_t           ctrl_q;
    logic             done_q;

    end_kind_e        kind;
    logic [IDX_W-1:0] sel_idx;
    logic [CNT_W-1:0] target;
    logic             running;
    logic             at_end;
    logic             tick;
    logic [CNT_W-1:0] stepped;

    always_comb begin
        kind    = end_kind(ctrl_q.endsel, NUM_MATCH);
        sel_idx = IDX_W'(ctrl_q.endsel - 3'd1);
        target  = '0;
        if (kind == END_MATCH)
            target = match_i[sel_idx];
    end

    assign running = !ctrl_q.stop && !done_q;
    assign at_end  = running && (kind != END_FREE) && (cnt_q == target);
    assign tick    = running && !at_end && (pre_q == div_q);
    assign stepped = ctrl_q.up ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            div_q  <= '0;
            pre_q  <= '0;
            ctrl_q <= CTRL_RESET;
            done_q <= 1'b0;
        end else begin
            if (val_we)
                cnt_q <= val_wdata;
            else if (tick)
                cnt_q <= stepped;

            if (div_we)
                div_q <= div_wdata;
            if (ctrl_we)
                ctrl_q <= ctrl_wdata;

            if (val_we || div_we || ctrl_we)
                pre_q <= '0;
            else if (tick)
                pre_q <= '0;
            else if (running && !at_end)
                pre_q <= pre_q + DIV_W'(1);

            if (val_we || ctrl_we)
                done_q <= 1'b0;
            else if (at_end)
                done_q <= 1'b1;
        end
    end

    always_comb begin
        hit_o = '0;
        if (at_end && kind == END_MATCH)
            hit_o[sel_idx] = 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign div_o  = div_q;
    assign ctrl_o = ctrl_q;

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.stop && !val_we) |=> (cnt_q == $past(cnt_q)));

    // R8
    end_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_q && !val_we) |=> $stable(cnt_q));

    // R4
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!val_we) |=> (cnt_q == $past(cnt_q) ||
                       cnt_q == $past(cnt_q) + CNT_W'(1) ||
                       cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R5
    pre_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pre_q <= div_q);

endmodule

// File: rtl/dmt_match_bank.sv
module dmt_match_bank #(
    parameter int CNT_W     = 16,
    parameter int NUM_MATCH = 6
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_MATCH-1:0]            we,
    input  logic [CNT_W-1:0]                wdata,
    output logic [NUM_MATCH-1:0][CNT_W-1:0] match_o
);

    for (genvar m = 0; m < NUM_MATCH; m++) begin : g_match
        logic [CNT_W-1:0] val_q;

        always_ff @(posedge clk) begin
            if (rst)
                val_q <= '0;
            else if (we[m])
                val_q <= wdata;
        end

        assign match_o[m] = val_q;
    end

endmodule

// File: rtl/dmt_irq_ctrl.sv
module dmt_irq_ctrl #(
    parameter int NUM_MATCH = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_MATCH-1:0] set_i,
    input  logic                 ack_we,
    input  logic                 mask_we,
    input  logic [NUM_MATCH-1:0] wbits,
    output logic [NUM_MATCH-1:0] status_o,
    output logic [NUM_MATCH-1:0] mask_o,
    output logic                 irq_o
);

    logic [NUM_MATCH-1:0] status_q;
    logic [NUM_MATCH-1:0] mask_q;
    logic [NUM_MATCH-1:0] clr;

    assign clr = ack_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= (status_q & ~clr) | set_i;
            if (mask_we)
                mask_q <= wbits;
        end
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;
    assign irq_o    = |(status_q & mask_q);

    // R10
    sticky_sts_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_we) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
    import dmt_pkg::*;
#(
    parameter int CNT_W     = DEF_CNT_W,
    parameter int NUM_MATCH = DEF_NUM_MATCH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_win,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    localparam int DIV_W = CNT_W;

    logic                                         tw_we;
    logic                                         iw_we;
    logic [NUM_TIMERS-1:0]                        val_we;
    logic [NUM_TIMERS-1:0]                        div_we;
    logic [NUM_TIMERS-1:0]                        ctrl_we;
    logic [NUM_MATCH-1:0]                         match_we;
    logic [NUM_TIMERS-1:0][CNT_W-1:0]             cnt_all;
    logic [NUM_TIMERS-1:0][DIV_W-1:0]             div_all;
    tctrl_t [NUM_TIMERS-1:0]                      ctrl_all;
    logic [NUM_TIMERS-1:0][NUM_MATCH-1:0]         hit_all;
    logic [NUM_MATCH-1:0][CNT_W-1:0]              match_vals;
    logic [NUM_MATCH-1:0]                         hit_any;
    logic [NUM_MATCH-1:0]                         status;
    logic [NUM_MATCH-1:0]                         mask;

    assign tw_we = bus_we && !bus_win;
    assign iw_we = bus_we && bus_win;

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
        assign val_we[t]  = tw_we && addr_is(bus_addr, t*GRP_STRIDE + OFF_VAL);
        assign div_we[t]  = tw_we && addr_is(bus_addr, t*GRP_STRIDE + OFF_DIV);
        assign ctrl_we[t] = tw_we && addr_is(bus_addr, t*GRP_STRIDE + OFF_CTRL);

        dmt_counter #(
            .CNT_W     (CNT_W),
            .NUM_MATCH (NUM_MATCH),
            .DIV_W     (DIV_W)
        ) u_cnt (
            .clk        (clk),
            .rst        (rst),
            .val_we     (val_we[t]),
            .div_we     (div_we[t]),
            .ctrl_we    (ctrl_we[t]),
            .val_wdata  (bus_wdata[CNT_W-1:0]),
            .div_wdata  (bus_wdata[DIV_W-1:0]),
            .ctrl_wdata (tctrl_t'(bus_wdata[4:0])),
            .match_i    (match_vals),
            .cnt_o      (cnt_all[t]),
            .div_o      (div_all[t]),
            .ctrl_o     (ctrl_all[t]),
            .hit_o      (hit_all[t])
        );
    end

    for (genvar m = 0; m < NUM_MATCH; m++) begin : g_mdec
        assign match_we[m] = tw_we && addr_is(bus_addr, OFF_MATCH + 4*m);
    end

    dmt_match_bank #(
        .CNT_W     (CNT_W),
        .NUM_MATCH (NUM_MATCH)
    ) u_match (
        .clk     (clk),
        .rst     (rst),
        .we      (match_we),
        .wdata   (bus_wdata[CNT_W-1:0]),
        .match_o (match_vals)
    );

    always_comb begin
        hit_any = '0;
        for (int t = 0; t < NUM_TIMERS; t++)
            hit_any = hit_any | hit_all[t];
    end

    dmt_irq_ctrl #(
        .NUM_MATCH (NUM_MATCH)
    ) u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_i    (hit_any),
        .ack_we   (iw_we && addr_is(bus_addr, OFF_STS)),
        .mask_we  (iw_we && addr_is(bus_addr, OFF_MSK)),
        .wbits    (bus_wdata[NUM_MATCH-1:0]),
        .status_o (status),
        .mask_o   (mask),
        .irq_o    (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (!bus_win) begin
            for (int t = 0; t < NUM_TIMERS; t++) begin
                if (addr_is(bus_addr, t*GRP_STRIDE + OFF_VAL))
                    bus_rdata = DATA_W'(cnt_all[t]);
                if (addr_is(bus_addr, t*GRP_STRIDE + OFF_DIV))
                    bus_rdata = DATA_W'(div_all[t]);
                if (addr_is(bus_addr, t*GRP_STRIDE + OFF_CTRL))
                    bus_rdata = DATA_W'(ctrl_all[t]);
            end
            for (int m = 0; m < NUM_MATCH; m++) begin
                if (addr_is(bus_addr, OFF_MATCH + 4*m))
                    bus_rdata = DATA_W'(match_vals[m]);
            end
        end else begin
            if (addr_is(bus_addr, OFF_STS))
                bus_rdata = DATA_W'(status);
            if (addr_is(bus_addr, OFF_MSK))
                bus_rdata = DATA_W'(mask);
        end
    end

    // R11
    irq_needs_sts_chk: assert property (@(posedge clk) disable iff (rst)
        (status == '0) |-> !irq_o);

endmodule

// File: tb/dual_match_timer_bench.sv
module dual_match_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_win = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dual_match_timer u_dual_match_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_win   (bus_win),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // {win, addr, wdata, expected readback}
    localparam logic [72:0] VEC [12] = '{
        {1'b0, 8'h00, 32'hFFFF_ABCD, 32'h0000_ABCD},
        {1'b0, 8'h04, 32'h0000_0005, 32'h0000_0005},
        {1'b0, 8'h08, 32'hFFFF_FFFF, 32'h0000_001F},
        {1'b0, 8'h0C, 32'h0000_1234, 32'h0000_1234},
        {1'b0, 8'h10, 32'h0000_00FF, 32'h0000_00FF},
        {1'b0, 8'h14, 32'h0000_0013, 32'h0000_0013},
        {1'b0, 8'h18, 32'h0000_A5A5, 32'h0000_A5A5},
        {1'b0, 8'h2C, 32'h0000_5A5A, 32'h0000_5A5A},
        {1'b0, 8'h20, 32'h0000_0101, 32'h0000_0101},
        {1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0000_003F},
        {1'b0, 8'h30, 32'h0000_DEAD, 32'h0000_0000},
        {1'b1, 8'h08, 32'h0000_BEEF, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic w, input logic [7:0] a, input logic [31:0] d);
        bus_win   = w;
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic w, input logic [7:0] a, output logic [31:0] d);
        bus_win  = w;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic w, input logic [7:0] a,
                          input logic [31:0] exp);
        logic [31:0] d;
        rd(w, a, d);
        check(req, d, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        rd_chk("R1", 1'b0, 8'h00, 32'h0);
        rd_chk("R1", 1'b0, 8'h04, 32'h0);
        rd_chk("R1", 1'b0, 8'h08, 32'h10);
        rd_chk("R1", 1'b0, 8'h0C, 32'h0);
        rd_chk("R1", 1'b0, 8'h14, 32'h10);
        rd_chk("R1", 1'b0, 8'h18, 32'h0);
        rd_chk("R1", 1'b0, 8'h2C, 32'h0);
        rd_chk("R1", 1'b1, 8'h00, 32'h0);
        rd_chk("R1", 1'b1, 8'h04, 32'h0);
        check("R1", 32'(irq_o), 32'h0);

        // R2 map readback, R13 unmapped reads
        for (int i = 0; i < 12; i++) begin
            wr(VEC[i][72], VEC[i][71:64], VEC[i][63:32]);
            rd_chk((i < 10) ? "R2" : "R13", VEC[i][72], VEC[i][71:64], VEC[i][31:0]);
        end

        do_reset();

        // R3 stopped counter holds
        wr(1'b0, 8'h00, 32'd7);
        wait_cyc(4);
        rd_chk("R3", 1'b0, 8'h00, 32'd7);

        // R5 divider 2: step every 3 clocks; R4 up count
        wr(1'b0, 8'h04, 32'd2);
        wr(1'b0, 8'h00, 32'd0);
        wr(1'b0, 8'h08, 32'h0F);
        wait_cyc(2);
        rd_chk("R5", 1'b0, 8'h00, 32'd0);
        wait_cyc(1);
        rd_chk("R5", 1'b0, 8'h00, 32'd1);
        wait_cyc(3);
        rd_chk("R4", 1'b0, 8'h00, 32'd2);

        // R6 up wrap
        wr(1'b0, 8'h08, 32'h10);
        wr(1'b0, 8'h04, 32'd0);
        wr(1'b0, 8'h00, 32'hFFFE);
        wr(1'b0, 8'h08, 32'h0F);
        wait_cyc(1);
        rd_chk("R6", 1'b0, 8'h00, 32'hFFFF);
        wait_cyc(1);
        rd_chk("R6", 1'b0, 8'h00, 32'h0000);

        // R6 down wrap, R4 down count
        wr(1'b0, 8'h08, 32'h10);
        wr(1'b0, 8'h00, 32'd1);
        wr(1'b0, 8'h08, 32'h07);
        wait_cyc(1);
        rd_chk("R4", 1'b0, 8'h00, 32'h0000);
        wait_cyc(1);
        rd_chk("R6", 1'b0, 8'h00, 32'hFFFF);

        // R7 count to zero, hold, no status
        wr(1'b0, 8'h08, 32'h10);
        wr(1'b0, 8'h00, 32'd2);
        wr(1'b0, 8'h08, 32'h00);
        wait_cyc(2);
        rd_chk("R7", 1'b0, 8'h00, 32'd0);
        wait_cyc(3);
        rd_chk("R7", 1'b0, 8'h00, 32'd0);
        rd_chk("R7", 1'b1, 8'h00, 32'h0);

        // R8 timer 1 ends at match register 2
        wr(1'b0, 8'h08, 32'h10);
        wr(1'b0, 8'h20, 32'd1);
        wr(1'b0, 8'h00, 32'd3);
        wr(1'b0, 8'h08, 32'h03);
        wait_cyc(2);
        rd_chk("R8", 1'b0, 8'h00, 32'd1);
        rd_chk("R8", 1'b1, 8'h00, 32'h0);
        wait_cyc(1);
        rd_chk("R8", 1'b1, 8'h00, 32'h04);
        check("R11", 32'(irq_o), 32'h0);
        wait_cyc(4);
        rd_chk("R8", 1'b0, 8'h00, 32'd1);

        // R11 mask gating
        wr(1'b1, 8'h04, 32'h04);
        check("R11", 32'(irq_o), 32'h1);
        wr(1'b1, 8'h04, 32'h03);
        check("R11", 32'(irq_o), 32'h0);

        // R10 write-one-to-clear
        wr(1'b1, 8'h00, 32'h00);
        rd_chk("R10", 1'b1, 8'h00, 32'h04);
        wr(1'b1, 8'h00, 32'h04);
        rd_chk("R10", 1'b1, 8'h00, 32'h00);

        // R9 release by value write
        wr(1'b0, 8'h00, 32'd4);
        wait_cyc(1);
        rd_chk("R9", 1'b0, 8'h00, 32'd3);
        wait_cyc(3);
        rd_chk("R9", 1'b0, 8'h00, 32'd1);
        rd_chk("R9", 1'b1, 8'h00, 32'h04);
        // R9 release by control write
        wr(1'b0, 8'h08, 32'h07);
        wait_cyc(1);
        rd_chk("R9", 1'b0, 8'h00, 32'd0);

        // R8 timer 2 up to match register 5
        do_reset();
        wr(1'b0, 8'h2C, 32'd5);
        wr(1'b0, 8'h0C, 32'd2);
        wr(1'b0, 8'h14, 32'h0E);
        wait_cyc(4);
        rd_chk("R8", 1'b1, 8'h00, 32'h20);
        rd_chk("R8", 1'b0, 8'h0C, 32'd5);
        rd_chk("R8", 1'b0, 8'h00, 32'd0);

        // R12 set beats same-cycle clear
        do_reset();
        wr(1'b0, 8'h18, 32'd0);
        wr(1'b0, 8'h00, 32'd2);
        wr(1'b0, 8'h08, 32'h01);
        wait_cyc(2);
        wr(1'b1, 8'h00, 32'h01);
        rd_chk("R12", 1'b1, 8'h00, 32'h01);
        wr(1'b1, 8'h00, 32'h01);
        rd_chk("R12", 1'b1, 8'h00, 32'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule